// File: doc/BRIEF.md
# Dual-Sample ADC Serial Streamer

This block moves 8-bit converter samples to a host controller over a three-wire synchronous serial link made of clock, frame and data. The link clock is the block's own clock `clk`, which runs faster than the converter. Each converter sample reaches the block as a one-cycle `smp_vld` strobe that is already synchronous to `clk`. The block emits one data bit per `clk` cycle. The host receiver samples the data line on the falling edge.

In dual mode, two consecutive samples are packed into one 16-bit word, so the host collects two samples for every read of its receive register. In single mode, each word is 8 bits and carries the newest sample alone. A word is loaded at a fixed word boundary from whatever was newest at that moment. The slower converter stream is therefore thinned out, and the gaps between the samples that get sent follow an irregular pattern.

A gate input blanks the frame and data lines. The word timing keeps running while the gate is high.

Top module: `adc_pair_streamer`

## Requirements
- R1: A synchronous active-high `rst` clears the bit counter, the shift register and the pairing state, and sets dual mode. The first word after reset is therefore 16 zero bits, and its frame is high from the first cycle.
- R2: In dual mode the word holds two consecutive accepted samples. The earlier sample is in bits 15:8 and the later sample is in bits 7:0.
- R3: With `gate` low, `ser_frm` is high for the first half of each word (bit counts 0 to 3 in single mode, 0 to 7 in dual mode) and low for the rest. Its rise marks the cycle that carries the word's most significant bit.
- R4: `ser_dat` presents the word most significant bit first, one bit per cycle, and changes only after a rising clock edge.
- R5: At each word boundary the shift register takes the newest completed pair. A sample that arrives in the boundary cycle itself waits for the next boundary. If no new pair has completed since the last boundary, the previous pair is sent again.
- R6: `mode_dual` is sampled only at a word boundary. 1 selects 16-bit dual-sample words. 0 selects 8-bit words that carry the newest single sample.
- R7: While `gate` is 1, both `ser_frm` and `ser_dat` are 0. The word timing and the loads continue unchanged underneath.
- R8: In dual mode, a lone first sample is not sent until its partner arrives. Until then the previous completed pair is repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe marking a new converter sample |
| smp_dat | input | 8 | Converter sample value |
| mode_dual | input | 1 | 1 selects 16-bit dual-sample words, 0 selects 8-bit single-sample words |
| gate | input | 1 | Forces the frame and data outputs low while 1 |
| ser_frm | output | 1 | Frame line; its rise starts a word |
| ser_dat | output | 1 | Serial data, most significant bit first |

## Verification
The bench sweeps several sample-strobe densities against both word lengths. These include a strobe on every cycle, a sparse strobe that leaves a pair half-filled across word boundaries, and an irregular 0.565 ratio close to the real clock relation. Each case hunts for a specific fault. A swapped pair order would show up as byte-swapped words. Loading at the wrong cycle would leak a sample that arrived during the boundary into the current word. A mode taken before the boundary would tear a word between 8 and 16 bits. A gate that also stalled the counter would shift every later word boundary.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

   typedef enum logic {
      WM_SINGLE = 1'b0,
      WM_DUAL   = 1'b1
   } word_mode_e;

   function automatic int unsigned ctr_width(input int unsigned smp_w, input int unsigned lanes);
      return $clog2(smp_w * lanes);
   endfunction

endpackage

// File: rtl/adc_pair_collect.sv
module adc_pair_collect
   import adc_ser_pkg::*;
#(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned LANES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     smp_vld,
   input  logic [SMP_W-1:0]         smp_dat,
   output logic [LANES*SMP_W-1:0]   pair_q,
   output logic [SMP_W-1:0]         last_q,
   output logic [SMP_W-1:0]         first_q,
   output logic                     pend_q
);
   localparam int unsigned WORD_W = LANES * SMP_W;
   localparam int unsigned IDX_W  = (LANES > 2) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

   logic [SMP_W-1:0] stage_q [LANES-1];
   logic [IDX_W-1:0] idx_q;
   logic [WORD_W-1:0] pair_nxt;
   logic             close_pair;

   assign close_pair = smp_vld && (idx_q == LAST_IDX);

   for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
      assign pair_nxt[(LANES-k)*SMP_W-1 -: SMP_W] = stage_q[k];
   end
   assign pair_nxt[SMP_W-1:0] = smp_dat;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q  <= '0;
         pair_q <= '0;
         last_q <= '0;
         for (int k = 0; k < LANES - 1; k++) begin
            stage_q[k] <= '0;
         end
      end else if (smp_vld) begin
         last_q <= smp_dat;
         if (close_pair) begin
            pair_q <= pair_nxt;
            idx_q  <= '0;
         end else begin
            for (int k = 0; k < LANES - 1; k++) begin
               if (idx_q == IDX_W'(k)) begin
                  stage_q[k] <= smp_dat;
               end
            end
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign first_q = stage_q[0];
   assign pend_q  = (idx_q != '0);

endmodule

// File: rtl/adc_word_timer.sv
module adc_word_timer
   import adc_ser_pkg::*;
#(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned LANES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  word_mode_e                           mode_in,
   output logic [ctr_width(SMP_W, LANES)-1:0]   cnt_q,
   output word_mode_e                           mode_q,
   output logic                                 load,
   output logic                                 frame
);
   localparam int unsigned CNT_W = ctr_width(SMP_W, LANES);
   localparam logic [CNT_W-1:0] END_S  = CNT_W'(SMP_W - 1);
   localparam logic [CNT_W-1:0] END_D  = CNT_W'(LANES * SMP_W - 1);
   localparam logic [CNT_W-1:0] HALF_S = CNT_W'(SMP_W / 2);
   localparam logic [CNT_W-1:0] HALF_D = CNT_W'((LANES * SMP_W) / 2);

   logic [CNT_W-1:0] end_cnt;
   logic [CNT_W-1:0] half_cnt;

   assign end_cnt  = (mode_q == WM_DUAL) ? END_D  : END_S;
   assign half_cnt = (mode_q == WM_DUAL) ? HALF_D : HALF_S;
   assign load     = (cnt_q == end_cnt);
   assign frame    = (cnt_q < half_cnt);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         mode_q <= WM_DUAL;
      end else if (load) begin
         cnt_q  <= '0;
         mode_q <= mode_in;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/adc_word_shifter.sv
module adc_word_shifter
   import adc_ser_pkg::*;
#(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned LANES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  word_mode_e               mode_nxt,
   input  logic [LANES*SMP_W-1:0]   pair,
   input  logic [SMP_W-1:0]         last,
   output logic [LANES*SMP_W-1:0]   sh_q
);
   localparam int unsigned WORD_W = LANES * SMP_W;

   logic [WORD_W-1:0] single_w;
   logic [WORD_W-1:0] load_w;

   for (genvar k = 0; k < LANES; k++) begin : g_single
      if (k == 0) begin : g_top
         assign single_w[WORD_W-1 -: SMP_W] = last;
      end else begin : g_pad
         assign single_w[(LANES-k)*SMP_W-1 -: SMP_W] = '0;
      end
   end

   assign load_w = (mode_nxt == WM_DUAL) ? pair : single_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_w;
      end else begin
         sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/adc_pair_streamer.sv
module adc_pair_streamer
   import adc_ser_pkg::*;
#(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned LANES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               smp_vld,
   input  logic [SMP_W-1:0]   smp_dat,
   input  logic               mode_dual,
   input  logic               gate,
   output logic               ser_frm,
   output logic               ser_dat
);
   localparam int unsigned WORD_W = LANES * SMP_W;
   localparam int unsigned CNT_W  = ctr_width(SMP_W, LANES);

   if (SMP_W < 2 || (SMP_W % 2) != 0) begin : g_bad_width
      $error("SMP_W must be even and at least 2");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("LANES must be 2 for dual-sample words");
   end

   logic [WORD_W-1:0] pair_w;
   logic [SMP_W-1:0]  last_w;
   logic [SMP_W-1:0]  first_w;
   logic              pend_w;
   logic [CNT_W-1:0]  cnt_w;
   word_mode_e        mode_w;
   word_mode_e        mode_in_w;
   logic              load_w;
   logic              frame_w;
   logic [WORD_W-1:0] sh_w;

   assign mode_in_w = mode_dual ? WM_DUAL : WM_SINGLE;

   adc_pair_collect #(.SMP_W(SMP_W), .LANES(LANES)) u_collect (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .smp_dat (smp_dat),
      .pair_q  (pair_w),
      .last_q  (last_w),
      .first_q (first_w),
      .pend_q  (pend_w)
   );

   adc_word_timer #(.SMP_W(SMP_W), .LANES(LANES)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .mode_in (mode_in_w),
      .cnt_q   (cnt_w),
      .mode_q  (mode_w),
      .load    (load_w),
      .frame   (frame_w)
   );

   adc_word_shifter #(.SMP_W(SMP_W), .LANES(LANES)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .load     (load_w),
      .mode_nxt (mode_in_w),
      .pair     (pair_w),
      .last     (last_w),
      .sh_q     (sh_w)
   );

   assign ser_frm = frame_w & ~gate;
   assign ser_dat = sh_w[WORD_W-1] & ~gate;

endmodule

// File: rtl/adc_pair_streamer_chk.sv
module adc_pair_streamer_chk
   import adc_ser_pkg::*;
#(
   parameter int unsigned SMP_W = 8,
   parameter int unsigned LANES = 2
) (
   input logic                                 clk,
   input logic                                 rst,
   input logic                                 gate,
   input logic                                 smp_vld,
   input logic [SMP_W-1:0]                     smp_dat,
   input logic                                 ser_frm,
   input logic                                 ser_dat,
   input logic                                 load,
   input logic [ctr_width(SMP_W, LANES)-1:0]   cnt,
   input word_mode_e                           mode_q,
   input logic [LANES*SMP_W-1:0]               sh,
   input logic [LANES*SMP_W-1:0]               pair,
   input logic [SMP_W-1:0]                     first,
   input logic                                 pend
);
   localparam int unsigned WORD_W = LANES * SMP_W;

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (cnt == '0 && sh == '0 && !pend && mode_q == WM_DUAL));

   a_r2_first_upper: assert property (@(posedge clk) disable iff (rst)
      ($past(smp_vld) && $past(pend) && !$past(rst))
      |-> (pair[WORD_W-1 -: SMP_W] == $past(first) && pair[SMP_W-1:0] == $past(smp_dat)));

   a_r3_frame_rise_at_start: assert property (@(posedge clk) disable iff (rst)
      ($rose(ser_frm) && !$past(gate)) |-> (cnt == '0));

   a_r4_shift_msb_first: assert property (@(posedge clk) disable iff (rst)
      (!$past(load) && !$past(rst)) |-> (sh == {$past(sh[WORD_W-2:0]), 1'b0}));

   a_r5_load_pair: assert property (@(posedge clk) disable iff (rst)
      ($past(load) && !$past(rst) && mode_q == WM_DUAL) |-> (sh == $past(pair)));

   a_r6_mode_at_boundary: assert property (@(posedge clk) disable iff (rst)
      (!$past(load) && !$past(rst)) |-> $stable(mode_q));

   a_r7_gate_blanks: assert property (@(posedge clk) disable iff (rst)
      gate |-> (!ser_frm && !ser_dat));

endmodule

bind adc_pair_streamer adc_pair_streamer_chk #(.SMP_W(SMP_W), .LANES(LANES)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .gate    (gate),
   .smp_vld (smp_vld),
   .smp_dat (smp_dat),
   .ser_frm (ser_frm),
   .ser_dat (ser_dat),
   .load    (load_w),
   .cnt     (cnt_w),
   .mode_q  (mode_w),
   .sh      (sh_w),
   .pair    (pair_w),
   .first   (first_w),
   .pend    (pend_w)
);

// File: tb/test_adc_pair_streamer.sv
module test_adc_pair_streamer;
   localparam int PERIOD = 10;
   localparam int MAX_CYC = 200000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       smp_vld = 1'b0;
   logic [7:0] smp_dat = 8'h00;
   logic       mode_dual = 1'b1;
   logic       gate = 1'b0;
   logic       ser_frm;
   logic       ser_dat;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string ph = "R1";

   always #(PERIOD/2) clk = ~clk;

   adc_pair_streamer i_adc_pair_streamer (
      .clk       (clk),
      .rst       (rst),
      .smp_vld   (smp_vld),
      .smp_dat   (smp_dat),
      .mode_dual (mode_dual),
      .gate      (gate),
      .ser_frm   (ser_frm),
      .ser_dat   (ser_dat)
   );

   // Requirement model: word timing, word content and pairing as stated in the brief.
   logic [3:0]  m_cnt  = 4'd0;
   logic        m_dual = 1'b1;
   logic [15:0] m_word = 16'h0;
   logic        m_half = 1'b0;
   logic [7:0]  m_hold = 8'h0;
   logic [15:0] m_pair = 16'h0;
   logic [7:0]  m_last = 8'h0;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt  <= 4'd0;
         m_dual <= 1'b1;
         m_word <= 16'h0;
         m_half <= 1'b0;
         m_hold <= 8'h0;
         m_pair <= 16'h0;
         m_last <= 8'h0;
      end else begin
         if (m_cnt == (m_dual ? 4'd15 : 4'd7)) begin
            m_cnt  <= 4'd0;
            m_dual <= mode_dual;
            m_word <= mode_dual ? m_pair : {m_last, 8'h00};
         end else begin
            m_cnt <= m_cnt + 4'd1;
         end
         if (smp_vld) begin
            m_last <= smp_dat;
            if (!m_half) begin
               m_hold <= smp_dat;
               m_half <= 1'b1;
            end else begin
               m_pair <= {m_hold, smp_dat};
               m_half <= 1'b0;
            end
         end
      end
   end

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
      end
   endtask

   bit started = 1'b0;
   always @(posedge clk) started <= 1'b1;

   always @(negedge clk) begin
      if (started && !done) begin
         logic e_frm;
         logic e_dat;
         string tf;
         string td;
         e_frm = !gate && (m_cnt < (m_dual ? 4'd8 : 4'd4));
         e_dat = !gate && m_word[4'd15 - m_cnt];
         tf = rst ? "R1" : (gate ? "R7" : "R3");
         td = rst ? "R1" : (gate ? "R7" : ph);
         check(tf, "ser_frm", ser_frm, e_frm);
         check(td, "ser_dat", ser_dat, e_dat);
      end
   end

   int acc = 0;

   // pat: 0 none, 1 every cycle, 2 every third, 3 ratio 0.565
   task automatic run(input int n, input int pat, input int mode_pat, input int gate_pat);
      for (int i = 0; i < n; i++) begin
         logic v;
         @(negedge clk);
         #1;
         case (pat)
            1: v = 1'b1;
            2: v = ((i % 3) == 0);
            3: begin
               acc = acc + 565;
               v = (acc >= 1000);
               if (acc >= 1000) acc = acc - 1000;
            end
            default: v = 1'b0;
         endcase
         smp_vld = v;
         if (v) smp_dat = smp_dat + 8'd1;
         if (mode_pat == 2) mode_dual = ((i / 5) % 2) == 0;
         else mode_dual = (mode_pat == 1);
         gate = (gate_pat != 0) && (((i / gate_pat) % 2) == 1);
      end
      @(negedge clk);
      #1;
      smp_vld = 1'b0;
      gate = 1'b0;
   endtask

   initial begin
      ph = "R1";
      rst = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      rst = 1'b0;
      run(40, 0, 1, 0);           // R1 zero word, R5 repeat with no new pair
      ph = "R2";
      run(200, 1, 1, 0);          // R2 dense pairs
      ph = "R8";
      run(240, 2, 1, 0);          // R8 half-filled pair across boundaries
      ph = "R5";
      run(600, 3, 1, 0);          // R5 irregular decimation
      ph = "R6";
      run(300, 3, 0, 0);          // R6 single-sample words
      run(400, 1, 2, 0);          // R6 mode flips mid-word
      ph = "R7";
      run(300, 3, 1, 7);          // R7 gating with timing running
      ph = "R4";
      run(300, 1, 1, 0);          // R4 ramp data bit order
      ph = "R1";
      rst = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      rst = 1'b0;
      run(100, 3, 1, 0);          // R1 mid-run reset
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(PERIOD * MAX_CYC);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule